// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the timing for a TFT raster panel. It emits a pixel clock enable, a pixel clock output, horizontal and vertical sync, data enable, the current pixel and line position, and a frame-done pulse. A reference clock is divided down to the pixel rate. Each line is counted in pixel clock enables and each frame is counted in lines. The panel geometry and the signal polarities are set by three packed 32-bit configuration words. A control word holds the divisor and the raster enable bit.

Timing fields are stored in a mix of encodings. The horizontal porches and the horizontal sync width are stored minus one, and their high bits sit in a third word. The vertical porches are stored as they are, while the vertical sync width is stored minus one. The active width is programmed in steps of 16 pixels. The block takes a copy of the configuration words only while it is idle or at the last reference cycle of a frame. Software can therefore rewrite the words at any time without tearing the current frame.

Top module: `raster_timer`

## Requirements
- R1: `pix_ce` pulses for one reference cycle once every D reference cycles, where D is `ctrl_word[15:8]`. A value of 0 or 1 is treated as D = 2. Two pulses are never adjacent.
- R2: A line lasts W + HFP + HSW + HBP pixel clock enables, and `px_cnt` counts 0 to that total minus 1. The terms are:
  - W = 16 × (P + 1), with P = {`hcfg_word[6]`, `hcfg_word[5:0]`}.
  - HFP = {`xcfg_word[1:0]`, `hcfg_word[20:13]`} + 1.
  - HSW = {`xcfg_word[7:4]`, `hcfg_word[12:7]`} + 1.
  - HBP = {`xcfg_word[3:2]`, `hcfg_word[28:21]`} + 1.
- R3: A frame lasts H + VFP + VSW + VBP lines, and `ln_cnt` counts 0 to that total minus 1, advancing at the end of each line. The terms are:
  - H = {`xcfg_word[8]`, `vcfg_word[31:22]`} + 1.
  - VFP = `vcfg_word[7:0]`.
  - VBP = `vcfg_word[15:8]`.
  - VSW = `vcfg_word[21:16]` + 1.
- R4: Each line runs through the active pixels, then front porch, then sync, then back porch. Each frame runs through the same four regions, counted in lines. `de` is high exactly when `px_cnt` < W and `ln_cnt` < H.
- R5: Before inversion, `hsync` is high while `px_cnt` is in the horizontal sync region, and `vsync` is high for whole lines in the vertical sync region. `xcfg_word[9]` inverts `hsync` and `xcfg_word[10]` inverts `vsync`.
- R6: Before inversion, `pclk_out` is low for the first floor(D/2) reference cycles of each pixel period and high for the rest. `xcfg_word[11]` inverts it.
- R7: When `xcfg_word[12]` and `xcfg_word[13]` are both 1, the sync outputs change on the pixel clock rising edge. They are then delayed by floor(D/2) reference cycles. In every other setting the syncs change together with the counters, which is the falling edge.
- R8: `frame_done` is a single-cycle pulse in the first cycle in which `ln_cnt` equals H, the first line of vertical front porch.
- R9: After reset, and while the raster is stopped, `pix_ce`, `de`, `frame_done`, `px_cnt` and `ln_cnt` are all 0.
  - Setting `ctrl_word[0]` starts the raster from position 0 on the next cycle.
  - Clearing `ctrl_word[0]` lets the current frame run to its end, and then the raster stops.
- R10: Configuration changes made while a frame is running have no effect until the frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Raster enable (bit 0) and pixel divisor (bits 15:8) |
| hcfg_word | input | 32 | Low parts of the line width and horizontal timing fields |
| vcfg_word | input | 32 | Vertical porches, vertical sync width, low bits of line count |
| xcfg_word | input | 32 | High bits of the horizontal fields and line count, polarity and edge select |
| pix_ce | output | 1 | Pixel clock enable, one reference cycle wide |
| pclk_out | output | 1 | Pixel clock output with selectable polarity |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable for active pixels |
| px_cnt | output | HCW | Pixel position within the line |
| ln_cnt | output | VCW | Line position within the frame |
| frame_done | output | 1 | Pulse at the first line of vertical front porch |

## Verification
Every output comes from registers. A reference clock edge therefore shows in the counters, `pix_ce`, `de` and `frame_done` in the cycle after that edge. In rising-edge mode the syncs show a further floor(D/2) cycles later. A start request is seen one cycle after the enable is written, and a new configuration is first seen one cycle after the frame's last reference cycle. The bench keeps to these delays with a behavioural model that is advanced on the rising edge from the same inputs. The model is compared against every output on the falling edge. Line lengths are also measured independently as the count of pixel enables between rising edges of `de`.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int HCW = 13,
  parameter int VCW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    ctrl_word,
  input  logic [31:0]    hcfg_word,
  input  logic [31:0]    vcfg_word,
  input  logic [31:0]    xcfg_word,
  output logic           pix_ce,
  output logic           pclk_out,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic [HCW-1:0] px_cnt,
  output logic [VCW-1:0] ln_cnt,
  output logic           frame_done
);
  localparam int DW = 8;

  logic [DW-1:0] div_q;
  logic [6:0]    ppl_q;
  logic [9:0]    hfp_q, hsw_q, hbp_q;
  logic [10:0]   lpp_q;
  logic [7:0]    vfp_q, vbp_q;
  logic [5:0]    vsw_q;
  logic          inv_h_q, inv_v_q, inv_p_q, esel_q, erise_q;

  logic           running;
  logic [DW-1:0]  dcnt;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic [1:0]     sync_q;
  logic           fdone_q;

  logic [DW-1:0]  dv, half;
  logic [HCW-1:0] act_w, hs_beg, hs_end, h_last;
  logic [VCW-1:0] act_h, vs_beg, vs_end, v_last;
  logic           ce, line_end, frame_end, load;
  logic           hs_raw, vs_raw, rise;
  logic           unused_bits;

  assign dv   = (div_q < DW'(2)) ? DW'(2) : div_q;
  assign half = dv >> 1;

  assign act_w  = HCW'({ppl_q, 4'b0000}) + HCW'(16);
  assign hs_beg = act_w + HCW'(hfp_q) + HCW'(1);
  assign hs_end = hs_beg + HCW'(hsw_q) + HCW'(1);
  assign h_last = hs_end + HCW'(hbp_q);

  assign act_h  = VCW'(lpp_q) + VCW'(1);
  assign vs_beg = act_h + VCW'(vfp_q);
  assign vs_end = vs_beg + VCW'(vsw_q) + VCW'(1);
  assign v_last = vs_end + VCW'(vbp_q) - VCW'(1);

  assign ce        = running && (dcnt == dv - DW'(1));
  assign line_end  = ce && (hcnt == h_last);
  assign frame_end = line_end && (vcnt == v_last);
  assign load      = !running || frame_end;

  assign hs_raw = running && (hcnt >= hs_beg) && (hcnt < hs_end);
  assign vs_raw = running && (vcnt >= vs_beg) && (vcnt < vs_end);
  assign rise   = esel_q & erise_q;

  assign pix_ce     = ce;
  assign pclk_out   = (running && (dcnt >= half)) ^ inv_p_q;
  assign de         = running && (hcnt < act_w) && (vcnt < act_h);
  assign hsync      = (rise ? (sync_q[1] & running) : hs_raw) ^ inv_h_q;
  assign vsync      = (rise ? (sync_q[0] & running) : vs_raw) ^ inv_v_q;
  assign px_cnt     = hcnt;
  assign ln_cnt     = vcnt;
  assign frame_done = fdone_q;

  assign unused_bits = ^{ctrl_word[31:16], ctrl_word[7:1], hcfg_word[31:29], xcfg_word[31:14]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ppl_q   <= '0;
      hfp_q   <= '0;
      hsw_q   <= '0;
      hbp_q   <= '0;
      lpp_q   <= '0;
      vfp_q   <= '0;
      vbp_q   <= '0;
      vsw_q   <= '0;
      inv_h_q <= 1'b0;
      inv_v_q <= 1'b0;
      inv_p_q <= 1'b0;
      esel_q  <= 1'b0;
      erise_q <= 1'b0;
    end else if (load) begin
      div_q   <= ctrl_word[15:8];
      ppl_q   <= {hcfg_word[6], hcfg_word[5:0]};
      hsw_q   <= {xcfg_word[7:4], hcfg_word[12:7]};
      hfp_q   <= {xcfg_word[1:0], hcfg_word[20:13]};
      hbp_q   <= {xcfg_word[3:2], hcfg_word[28:21]};
      lpp_q   <= {xcfg_word[8], vcfg_word[31:22]};
      vfp_q   <= vcfg_word[7:0];
      vbp_q   <= vcfg_word[15:8];
      vsw_q   <= vcfg_word[21:16];
      inv_h_q <= xcfg_word[9];
      inv_v_q <= xcfg_word[10];
      inv_p_q <= xcfg_word[11];
      esel_q  <= xcfg_word[12];
      erise_q <= xcfg_word[13];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      dcnt    <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!running) begin
      running <= ctrl_word[0];
      dcnt    <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else begin
      dcnt <= ce ? '0 : dcnt + DW'(1);
      if (ce)        hcnt    <= line_end ? '0 : hcnt + HCW'(1);
      if (line_end)  vcnt    <= frame_end ? '0 : vcnt + VCW'(1);
      if (frame_end) running <= ctrl_word[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b00;
      fdone_q <= 1'b0;
    end else begin
      fdone_q <= line_end && (vcnt == VCW'(lpp_q));
      if (!running)                   sync_q <= 2'b00;
      else if (dcnt == half - DW'(1)) sync_q <= {hs_raw, vs_raw};
    end
  end
endmodule

module raster_timer_chk #(
  parameter int HCW = 13,
  parameter int VCW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pix_ce,
  input logic           de,
  input logic [HCW-1:0] px_cnt,
  input logic [VCW-1:0] ln_cnt,
  input logic           frame_done
);
  AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n) pix_ce |=> !pix_ce); // R1
  AST_PX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pix_ce |=> $stable(px_cnt)); // R2
  AST_LN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pix_ce |=> $stable(ln_cnt)); // R3
  AST_DE_LINE_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(de) |-> (px_cnt == '0)); // R4
  AST_FD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done); // R8
  AST_FD_BLANK: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> !de); // R8
endmodule

bind raster_timer raster_timer_chk #(.HCW(HCW), .VCW(VCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .de(de),
  .px_cnt(px_cnt), .ln_cnt(ln_cnt), .frame_done(frame_done)
);

// File: tb/sim_raster_timer.sv
`timescale 1ns/1ps
module sim_raster_timer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [31:0] cw, hw, vw, xw;
  logic pix_ce, pclk_out, hsync, vsync, de, frame_done;
  logic [12:0] px_cnt;
  logic [11:0] ln_cnt;

  raster_timer u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(cw), .hcfg_word(hw), .vcfg_word(vw), .xcfg_word(xw),
    .pix_ce(pix_ce), .pclk_out(pclk_out), .hsync(hsync), .vsync(vsync), .de(de),
    .px_cnt(px_cnt), .ln_cnt(ln_cnt), .frame_done(frame_done)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model state
  int m_run, m_ph, m_hp, m_ln, m_sqh, m_sqv, m_fd;
  int s_div, s_ppl, s_hfp, s_hsw, s_hbp, s_lpp, s_vfp, s_vbp, s_vsw, s_ih, s_iv, s_ip, s_es, s_er;
  int g_D, g_half, g_W, g_Ht, g_H, g_Vt, g_hsb, g_hse, g_vsb, g_vse;

  task automatic m_load();
    s_div = cw[15:8];
    s_ppl = {hw[6], hw[5:0]};
    s_hsw = {xw[7:4], hw[12:7]};
    s_hfp = {xw[1:0], hw[20:13]};
    s_hbp = {xw[3:2], hw[28:21]};
    s_lpp = {xw[8], vw[31:22]};
    s_vfp = vw[7:0];
    s_vbp = vw[15:8];
    s_vsw = vw[21:16];
    s_ih = xw[9]; s_iv = xw[10]; s_ip = xw[11]; s_es = xw[12]; s_er = xw[13];
  endtask

  task automatic m_geo();
    g_D   = (s_div < 2) ? 2 : s_div;
    g_half = g_D / 2;
    g_W   = (s_ppl + 1) * 16;
    g_hsb = g_W + s_hfp + 1;
    g_hse = g_hsb + s_hsw + 1;
    g_Ht  = g_hse + s_hbp + 1;
    g_H   = s_lpp + 1;
    g_vsb = g_H + s_vfp;
    g_vse = g_vsb + s_vsw + 1;
    g_Vt  = g_vse + s_vbp;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_hp = 0; m_ln = 0; m_sqh = 0; m_sqv = 0; m_fd = 0;
      s_div = 0; s_ppl = 0; s_hfp = 0; s_hsw = 0; s_hbp = 0; s_lpp = 0;
      s_vfp = 0; s_vbp = 0; s_vsw = 0; s_ih = 0; s_iv = 0; s_ip = 0; s_es = 0; s_er = 0;
    end else begin
      int hr, vr, ce, le, fe;
      m_geo();
      hr = (m_run != 0) && m_hp >= g_hsb && m_hp < g_hse;
      vr = (m_run != 0) && m_ln >= g_vsb && m_ln < g_vse;
      ce = (m_run != 0) && m_ph == g_D - 1;
      le = ce && m_hp == g_Ht - 1;
      fe = le && m_ln == g_Vt - 1;
      m_fd = le && m_ln == g_H - 1;
      if (m_run == 0) begin m_sqh = 0; m_sqv = 0; end
      else if (m_ph == g_half - 1) begin m_sqh = hr; m_sqv = vr; end
      if (m_run == 0) begin
        m_load();
        m_run = cw[0]; m_ph = 0; m_hp = 0; m_ln = 0;
      end else begin
        m_ph = ce ? 0 : m_ph + 1;
        if (ce) m_hp = le ? 0 : m_hp + 1;
        if (le) m_ln = fe ? 0 : m_ln + 1;
        if (fe) begin m_load(); m_run = cw[0]; end
      end
    end
  end

  // line length measurement
  int meas_en = 0, seen = 0, ce_acc = 0, exp_htot = 0;
  logic de_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      int e_ce, e_pclk, e_de, hr, vr, rise, e_hs, e_vs;
      m_geo();
      e_ce  = (m_run != 0) && m_ph == g_D - 1;
      e_pclk = ((m_run != 0) && m_ph >= g_half) ^ s_ip;
      e_de  = (m_run != 0) && m_hp < g_W && m_ln < g_H;
      hr = (m_run != 0) && m_hp >= g_hsb && m_hp < g_hse;
      vr = (m_run != 0) && m_ln >= g_vsb && m_ln < g_vse;
      rise = (s_es != 0) && (s_er != 0);
      e_hs = (rise ? ((m_sqh != 0) && (m_run != 0)) : hr) ^ s_ih;
      e_vs = (rise ? ((m_sqv != 0) && (m_run != 0)) : vr) ^ s_iv;
      chk("R1 pix_ce", pix_ce, e_ce);
      chk("R6 pclk_out", pclk_out, e_pclk);
      chk("R4 de", de, e_de);
      chk(rise ? "R7 hsync" : "R5 hsync", hsync, e_hs);
      chk(rise ? "R7 vsync" : "R5 vsync", vsync, e_vs);
      chk("R2 px_cnt", px_cnt, m_hp);
      chk("R3 ln_cnt", ln_cnt, m_ln);
      chk("R8 frame_done", frame_done, m_fd);
      if (meas_en != 0) begin
        if (pix_ce) ce_acc++;
        if (de && !de_prev) begin
          if (seen != 0 && ln_cnt != 0) chk("R2 line length", ce_acc, exp_htot);
          seen = 1;
          ce_acc = 0;
        end
      end
    end
    de_prev = de;
  end

  task automatic drive(input logic [31:0] c, input logic [31:0] h, input logic [31:0] v, input logic [31:0] x);
    @(posedge clk); #1;
    cw = c; hw = h; vw = v; xw = x;
  endtask

  task automatic start(input logic [31:0] c, input logic [31:0] h, input logic [31:0] v, input logic [31:0] x, input int htot);
    meas_en = 1; seen = 0; ce_acc = 0; exp_htot = htot;
    drive(c, h, v, x);
  endtask

  task automatic wait_fd(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!frame_done) @(negedge clk);
    end
  endtask

  task automatic wait_frame_start();
    @(negedge clk);
    while (!(de && ln_cnt == 0 && px_cnt == 0)) @(negedge clk);
  endtask

  task automatic stop_run(input int exp_h);
    int cnt;
    wait_frame_start();
    drive(cw & ~32'd1, hw, vw, xw);
    wait_fd(1);
    chk("R9 frame completes after clear", ln_cnt, exp_h);
    @(negedge clk);
    while (ln_cnt != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pix_ce) cnt++;
    end
    chk("R9 no pixel enables when stopped", cnt, 0);
    chk("R9 de low when stopped", de, 0);
    chk("R9 px_cnt zero when stopped", px_cnt, 0);
    meas_en = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  localparam logic [31:0] VA = 32'h1 | (32'h1 << 8) | (32'h1 << 22);

  initial begin
    int cnt;
    rst_n = 1'b0; cw = '0; hw = '0; vw = '0; xw = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset de", de, 0);
    chk("R9 reset pix_ce", pix_ce, 0);
    chk("R9 reset frame_done", frame_done, 0);
    chk("R9 reset px_cnt", px_cnt, 0);

    // A: minimum geometry, divisor 2
    start(32'h1 | (32'd2 << 8), 32'h0, VA, 32'h0, 19);
    wait_fd(2);

    // R10: mid-frame rewrite of divisor and width is deferred
    wait_frame_start();
    meas_en = 0;
    drive(32'h1 | (32'd7 << 8), 32'h1, VA, 32'h0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pix_ce) cnt++;
    end
    chk("R10 divisor held mid-frame", cnt, 10);
    wait_fd(2);
    stop_run(2);

    // B: split high bits, odd divisor, all inversions, zero vertical porches
    start(32'h1 | (32'd5 << 8),
          32'h1 | (32'h1 << 7) | (32'h1 << 13) | (32'h2 << 21),
          32'h2 << 22,
          32'h1 | (32'h1 << 2) | (32'h1 << 4) | (32'h7 << 9), 615);
    wait_fd(1);
    stop_run(3);

    // C: divisor 1 clamps to 2, line count bit 10, rising-edge sync
    start(32'h1 | (32'd1 << 8), 32'h0,
          32'h2 | (32'h1 << 8) | (32'h1 << 16),
          (32'h1 << 8) | (32'h1 << 12) | (32'h1 << 13), 19);
    stop_run(1025);

    // D: width MSB, falling-edge select, hsync and pclk inverted
    start(32'h1 | (32'd3 << 8), (32'h1 << 6) | (32'h3 << 7) | (32'h4 << 21),
          32'h1 | (32'h1 << 8),
          (32'h1 << 12) | (32'h1 << 9) | (32'h1 << 11), 1050);
    wait_fd(1);
    stop_run(1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule